// File: doc/BRIEF.md
# Fractional Divider Parameter Encoder

This block turns a divide ratio given as an integer part `a` plus a fraction `b/c` into the three words that a fractional clock divider is loaded with. The first word is the integer part scaled by 128, plus the 7-bit floor of `128*b/c`, minus a fixed offset of 512. The second word is the remainder left after that floor is taken. The third word is the denominator, passed through unchanged.

A host places `a`, `b` and `c` on the inputs and pulses `start_i`. The block captures the operands and then runs seven steps of restoring division, one per clock. Because `b < c`, the quotient of `128*b/c` never needs more than seven bits. Once the division ends, the remainder is already the second output word, so no multiplier is needed. One more cycle assembles the first word, and `done_o` then pulses.

Operands that break the encoding rules are flagged on `err_o` in the same cycle as `done_o`. In that case the previously produced output words stay where they are. The latency is the same whether or not the operands are valid.

Top module: `div_param_encoder`

## Requirements
- R1: On a valid conversion, `p1_o` equals 128·a + floor(128·b/c) − 512.
- R2: On a valid conversion, `p2_o` equals 128·b − c·floor(128·b/c), which is always less than `c`.
- R3: On a valid conversion, `p3_o` equals `c`.
- R4: `done_o` is high in the cycle after the 9th rising edge, counting the edge that samples `start_i` high while the block is idle (1 capture + 7 division + 1 assembly).
- R5: `done_o` is high for exactly one cycle per accepted start.
- R6: A `start_i` pulse that arrives while a conversion is in progress is ignored: it produces no extra `done_o`, and the outputs reflect the operands captured first. A start in the cycle where `done_o` is high is accepted.
- R7: If `c` is zero, `err_o` is high together with `done_o`.
- R8: If `b` is greater than or equal to `c`, `err_o` is high together with `done_o`.
- R9: If `a` is below 4 or above 2000, `err_o` is high together with `done_o`. On any flagged conversion, `p1_o`, `p2_o` and `p3_o` keep their previous values. `err_o` is never high without `done_o`.
- R10: After reset, `p1_o`, `p2_o` and `p3_o` are zero, and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start a conversion (taken only when idle) |
| a_i | input | 12 | Integer part of the ratio |
| b_i | input | 20 | Fraction numerator |
| c_i | input | 20 | Fraction denominator |
| p1_o | output | 18 | Scaled integer word with offset |
| p2_o | output | 20 | Fraction remainder word |
| p3_o | output | 20 | Denominator word |
| done_o | output | 1 | One-cycle pulse: outputs are valid |
| err_o | output | 1 | Operands rejected; high only with `done_o` |

## Verification
Two events can fall in the same cycle: a conversion completing (`done_o` high) and a new start being accepted. The bench provokes this by raising `start_i` in exactly the cycle where `done_o` is seen. It judges the result by requiring a second `done_o` nine edges later, carrying the new operands' words. It also drives a start in the middle of a conversion and requires that this start yields no done pulse and does not alter the results. Flagged operands placed directly after a valid conversion show whether the held words survive a coincident completion.

// File: rtl/div_enc_pkg.sv
package div_enc_pkg;
  localparam int unsigned DEF_A_W       = 12;
  localparam int unsigned DEF_BC_W      = 20;
  localparam int unsigned DEF_FRAC_BITS = 7;
  localparam int unsigned DEF_OFFSET    = 512;
  localparam int unsigned DEF_A_MIN     = 4;
  localparam int unsigned DEF_A_MAX     = 2000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FORM = 2'd2
  } enc_state_e;
endpackage

// File: rtl/div_enc_rst_sync.sv
module div_enc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/div_enc_check.sv
module div_enc_check #(
  parameter int unsigned A_W   = 12,
  parameter int unsigned BC_W  = 20,
  parameter int unsigned A_MIN = 4,
  parameter int unsigned A_MAX = 2000
) (
  input  logic [A_W-1:0]  a_i,
  input  logic [BC_W-1:0] b_i,
  input  logic [BC_W-1:0] c_i,
  output logic            bad_o
);
  logic c_zero, b_high, a_low, a_high;

  always_comb begin
    c_zero = (c_i == '0);
    b_high = (b_i >= c_i);
    a_low  = ({{(32-A_W){1'b0}}, a_i} < A_MIN);
    a_high = ({{(32-A_W){1'b0}}, a_i} > A_MAX);
    bad_o  = c_zero | b_high | a_low | a_high;
  end
endmodule

// File: rtl/div_enc_step.sv
module div_enc_step #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic         qbit_o
);
  logic [W:0] shifted;
  logic [W:0] diff;

  always_comb begin
    shifted = {rem_i, 1'b0};
    diff    = shifted - {1'b0, div_i};
    qbit_o  = (shifted >= {1'b0, div_i});
    rem_o   = qbit_o ? diff[W-1:0] : shifted[W-1:0];
  end
endmodule

// File: rtl/div_enc_ctrl.sv
module div_enc_ctrl
  import div_enc_pkg::*;
#(
  parameter int unsigned STEPS = 7,
  localparam int unsigned CNT_W = $clog2(STEPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic cap_en_o,
  output logic step_en_o,
  output logic form_en_o
);
  enc_state_e       state_q, state_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    cap_en_o  = 1'b0;
    step_en_o = 1'b0;
    form_en_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en_o  = 1'b1;
          cnt_nxt   = '0;
          state_nxt = ST_DIV;
        end
      end
      ST_DIV: begin
        step_en_o = 1'b1;
        cnt_nxt   = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(STEPS - 1)) state_nxt = ST_FORM;
      end
      ST_FORM: begin
        form_en_o = 1'b1;
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/div_param_encoder.sv
module div_param_encoder
  import div_enc_pkg::*;
#(
  parameter int unsigned A_W       = DEF_A_W,
  parameter int unsigned BC_W      = DEF_BC_W,
  parameter int unsigned FRAC_BITS = DEF_FRAC_BITS,
  parameter int unsigned OFFSET    = DEF_OFFSET,
  parameter int unsigned A_MIN     = DEF_A_MIN,
  parameter int unsigned A_MAX     = DEF_A_MAX,
  localparam int unsigned SCALE    = 1 << FRAC_BITS,
  localparam int unsigned P1_W     = $clog2(A_MAX * SCALE + SCALE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [A_W-1:0]  a_i,
  input  logic [BC_W-1:0] b_i,
  input  logic [BC_W-1:0] c_i,
  output logic [P1_W-1:0] p1_o,
  output logic [BC_W-1:0] p2_o,
  output logic [BC_W-1:0] p3_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned SUM_W = P1_W + 1;

  logic rst_sync_n;
  logic cap_en, step_en, form_en, bad_in;
  logic [BC_W-1:0] step_rem;
  logic            step_qbit;

  logic [A_W-1:0]       a_q, a_nxt;
  logic [BC_W-1:0]      c_q, c_nxt;
  logic [BC_W-1:0]      rem_q, rem_nxt;
  logic [FRAC_BITS-1:0] quo_q, quo_nxt;
  logic                 bad_q, bad_nxt;
  logic [P1_W-1:0]      p1_q, p1_nxt;
  logic [BC_W-1:0]      p2_q, p2_nxt;
  logic [BC_W-1:0]      p3_q, p3_nxt;
  logic                 done_q, done_nxt;
  logic                 err_q, err_nxt;
  logic [SUM_W-1:0]     p1_sum;

  div_enc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  div_enc_ctrl #(.STEPS(FRAC_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (start_i),
    .cap_en_o  (cap_en),
    .step_en_o (step_en),
    .form_en_o (form_en)
  );

  div_enc_check #(
    .A_W(A_W), .BC_W(BC_W), .A_MIN(A_MIN), .A_MAX(A_MAX)
  ) u_check (
    .a_i   (a_i),
    .b_i   (b_i),
    .c_i   (c_i),
    .bad_o (bad_in)
  );

  div_enc_step #(.W(BC_W)) u_step (
    .rem_i  (rem_q),
    .div_i  (c_q),
    .rem_o  (step_rem),
    .qbit_o (step_qbit)
  );

  always_comb begin
    p1_sum = ({{(SUM_W-A_W){1'b0}}, a_q} << FRAC_BITS)
           + {{(SUM_W-FRAC_BITS){1'b0}}, quo_q}
           - SUM_W'(OFFSET);
  end

  always_comb begin
    a_nxt    = a_q;
    c_nxt    = c_q;
    rem_nxt  = rem_q;
    quo_nxt  = quo_q;
    bad_nxt  = bad_q;
    p1_nxt   = p1_q;
    p2_nxt   = p2_q;
    p3_nxt   = p3_q;
    done_nxt = 1'b0;
    err_nxt  = 1'b0;
    if (cap_en) begin
      a_nxt   = a_i;
      c_nxt   = c_i;
      rem_nxt = b_i;
      quo_nxt = '0;
      bad_nxt = bad_in;
    end
    if (step_en) begin
      rem_nxt = step_rem;
      quo_nxt = {quo_q[FRAC_BITS-2:0], step_qbit};
    end
    if (form_en) begin
      done_nxt = 1'b1;
      err_nxt  = bad_q;
      if (!bad_q) begin
        p1_nxt = p1_sum[P1_W-1:0];
        p2_nxt = rem_q;
        p3_nxt = c_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_q    <= '0;
      c_q    <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      bad_q  <= 1'b0;
      p1_q   <= '0;
      p2_q   <= '0;
      p3_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      a_q    <= a_nxt;
      c_q    <= c_nxt;
      rem_q  <= rem_nxt;
      quo_q  <= quo_nxt;
      bad_q  <= bad_nxt;
      p1_q   <= p1_nxt;
      p2_q   <= p2_nxt;
      p3_q   <= p3_nxt;
      done_q <= done_nxt;
      err_q  <= err_nxt;
    end
  end

  assign p1_o   = p1_q;
  assign p2_o   = p2_q;
  assign p3_o   = p3_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/div_param_encoder_chk.sv
module div_param_encoder_chk #(
  parameter int unsigned P1_W = 18,
  parameter int unsigned BC_W = 20
) (
  input logic            clk,
  input logic            rst_ok_n,
  input logic            start_i,
  input logic [BC_W-1:0] c_i,
  input logic [P1_W-1:0] p1_o,
  input logic [BC_W-1:0] p2_o,
  input logic [BC_W-1:0] p3_o,
  input logic            done_o,
  input logic            err_o
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done_o |=> !done_o);

  // R9
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    err_o |-> done_o);

  // R9
  held_on_err_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (done_o && err_o) |-> ($stable(p1_o) && $stable(p2_o) && $stable(p3_o)));

  // R2
  rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (done_o && !err_o) |-> (p2_o < p3_o));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done_o |-> $past(start_i, 9));

  // R3
  den_pass_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (done_o && !err_o) |-> (p3_o == $past(c_i, 9)));
endmodule

bind div_param_encoder div_param_encoder_chk #(.P1_W(P1_W), .BC_W(BC_W)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .start_i  (start_i),
  .c_i      (c_i),
  .p1_o     (p1_o),
  .p2_o     (p2_o),
  .p3_o     (p3_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/sim_div_param_encoder.sv
module sim_div_param_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] a_i = '0;
  logic [19:0] b_i = '0;
  logic [19:0] c_i = '0;
  logic [17:0] p1_o;
  logic [19:0] p2_o, p3_o;
  logic        done_o, err_o;

  typedef struct {
    longint p1; longint p2; longint p3;
    bit err; longint cyc; string tag;
  } exp_t;

  exp_t   sb[$];
  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  int     dones = 0;
  int     pushed = 0;
  longint last_p1 = 0, last_p2 = 0, last_p3 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  div_param_encoder u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .p1_o(p1_o), .p2_o(p2_o), .p3_o(p3_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // builds the expectation from the requirements and drives one start cycle
  task automatic push_and_start(input longint a, input longint b, input longint c, input string tag);
    exp_t e;
    bit bad;
    longint q;
    bad = (c == 0) || (b >= c) || (a < 4) || (a > 2000);
    if (!bad) begin
      q = (128 * b) / c;
      last_p1 = 128 * a + q - 512;
      last_p2 = 128 * b - c * q;
      last_p3 = c;
    end
    e.p1 = last_p1; e.p2 = last_p2; e.p3 = last_p3;
    e.err = bad; e.cyc = cyc + 9; e.tag = tag;
    sb.push_back(e);
    pushed++;
    a_i = a[11:0]; b_i = b[19:0]; c_i = c[19:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic run_one(input longint a, input longint b, input longint c, input string tag);
    push_and_start(a, b, c, tag);
    wait_done();
    @(negedge clk);
  endtask

  // monitor: pops and compares on every done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      dones++;
      if (sb.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.cyc, "R4 latency", cyc, e.cyc);
        chk(err_o == e.err, {"R7/R8/R9 err ", e.tag}, err_o, e.err);
        chk(p1_o == e.p1, {"R1 p1 ", e.tag}, p1_o, e.p1);
        chk(p2_o == e.p2, {"R2 p2 ", e.tag}, p2_o, e.p2);
        chk(p3_o == e.p3, {"R3 p3 ", e.tag}, p3_o, e.p3);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(p1_o == 0 && p2_o == 0 && p3_o == 0, "R10 words", p1_o, 0);
    chk(!done_o && !err_o, "R10 flags", {done_o, err_o}, 0);

    run_one(4, 0, 1, "min");
    run_one(100, 1, 3, "third");
    run_one(2000, 1048573, 1048574, "max");
    run_one(37, 5, 7, "mid");

    // flagged operands, words must hold: R7, R8, R9
    run_one(50, 3, 0, "R7 c zero");
    run_one(50, 9, 9, "R8 b equal c");
    run_one(50, 10, 9, "R8 b above c");
    run_one(3, 1, 2, "R9 a low");
    run_one(2001, 1, 2, "R9 a high");

    // R6 start during conversion ignored
    push_and_start(300, 2, 5, "R6 first");
    repeat (3) @(negedge clk);
    a_i = 12'd900; b_i = 20'd1; c_i = 20'd2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    // R6 start in the done cycle is accepted (back to back)
    push_and_start(1234, 777, 1000, "R6 back2back");
    wait_done();
    push_and_start(5, 0, 0, "R7 back2back err");
    wait_done();
    @(negedge clk);

    for (int i = 0; i < 20; i++) begin
      longint a, b, c;
      a = 4 + (i * 97 + 13) % 1997;
      c = 1 + (i * 524287 + 7919) % 1048574;
      b = (i * 65537 + 3) % c;
      run_one(a, b, c, "sweep");
    end

    repeat (12) @(negedge clk);
    // R5 one done per accepted start, none for the ignored one
    chk(dones == pushed, "R5 done count", dones, pushed);
    chk(sb.size() == 0, "R5 queue drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule